// File: doc/BRIEF.md
# Cascaded One-Hot Bit Tally

This block reports how many bits of an N-bit input word are set. The answer comes out as a one-hot vector of N+1 lines. Line k is high when exactly k input bits are 1.

The count is built by a chain of identical steering stages, one for each input bit. A seed vector with only position zero set enters the first stage. A stage whose bit is clear hands the vector on unchanged. A stage whose bit is set moves every position up by one index. Whatever would move past index N can never occur and is discarded. An encoder can turn the one-hot result into a binary count, and a parameter selects this option.

A second parameter selects whether the result passes straight to the outputs or is held in an output register. Results leave on a valid/ready stream.
- **Combinational build:** valid and ready pass through the block unchanged.
- **Registered build:** the block acts as a single-entry pipeline slot.
  - A word is accepted when `in_valid` and `in_ready` are both high at a rising edge.
  - `in_ready` is high when the slot is empty or the consumer is taking its content in the same cycle.
  - While `out_valid` is high and `out_ready` is low, the held result stays frozen and no new word is accepted.

Top module: `tally_steer`

## Requirements
- R1: `out_onehot[k]` is 1 exactly when k bits of the accepted input word are 1, for every k from 0 to N.
- R2: Exactly one bit of `out_onehot` is high at all times after reset, whatever the input.
- R3: An input word with no bit set yields `out_onehot` with only bit 0 high.
- R4: An input word with all N bits set yields only bit N high, and no position beyond N is produced.
- R5: With N=2, the inputs map as follows: 2'b00 sets bit 0, 2'b01 and 2'b10 each set bit 1, and 2'b11 sets bit 2.
- R6: With COUNT_EN=1, `out_count` is the number of set input bits as an unsigned binary value. With COUNT_EN=0, `out_count` is held at 0.
- R7: With REG_OUT=1, a word accepted at a rising edge appears on the outputs with `out_valid`=1 after that edge. A synchronous reset with `rst_n` low drives `out_valid`=0, `out_onehot`=1 (only bit 0 set) and `out_count`=0.
- R8: With REG_OUT=1, while `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_onehot` and `out_count` do not change. The held word leaves on the first edge at which `out_ready`=1.
- R9: With REG_OUT=0, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the result follows `in_bits` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock (used when REG_OUT=1) |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word |
| in_bits | input | N | Bits to tally |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_onehot | output | N+1 | One-hot tally, bit k means k ones |
| out_count | output | clog2(N+1) | Binary tally (0 when COUNT_EN=0) |

## Verification
The bench builds two copies of the block.

The first copy uses N=8 with the output register and the binary encoder enabled. This makes all 256 input words reachable one by one, so the one-hot invariant and the count can be checked exhaustively. It also lets the bench hold the output slot under back-pressure, and check the reset state.

The second copy uses N=2, purely combinational, with the encoder disabled. It covers the four-entry mapping of the smallest cascade, the valid/ready pass-through, and the count held at zero.

// File: rtl/tally_pkg.sv
package tally_pkg;
  // Routing choice made by one steering stage.
  typedef enum logic {
    STEER_STRAIGHT = 1'b0,
    STEER_DIAG     = 1'b1
  } steer_mode_e;

  // Width of a binary number able to hold the values 0..n.
  function automatic int unsigned count_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/tally_stage.sv
module tally_stage
  import tally_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         bit_i,
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] vec_o
);
  steer_mode_e mode;

  always_comb begin
    mode = bit_i ? STEER_DIAG : STEER_STRAIGHT;
    unique case (mode)
      STEER_STRAIGHT: vec_o = vec_i;
      // Every position moves up one index; the top position falls off and
      // index 0 is driven low so no line is ever left undriven.
      STEER_DIAG:     vec_o = {vec_i[W-2:0], 1'b0};
      default:        vec_o = vec_i;
    endcase
  end
endmodule

// File: rtl/tally_chain.sv
module tally_chain #(
  parameter int unsigned N = 8,
  localparam int unsigned W = N + 1
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] onehot_o
);
  logic [W-1:0] lane [0:N];

  // Seed: only the zero position is set.
  assign lane[0] = {{(W-1){1'b0}}, 1'b1};

  for (genvar s = 0; s < N; s++) begin : g_stage
    tally_stage #(.W(W)) stage_i (
      .bit_i (bits_i[s]),
      .vec_i (lane[s]),
      .vec_o (lane[s+1])
    );
  end

  assign onehot_o = lane[N];
endmodule

// File: rtl/tally_encode.sv
module tally_encode #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 4
) (
  input  logic [N:0]    onehot_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int k = 0; k <= int'(N); k++) begin
      if (onehot_i[k]) count_o = count_o | CW'(k);
    end
  end
endmodule

// File: rtl/tally_out_slot.sv
module tally_out_slot #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N:0]    onehot_d,
  input  logic [CW-1:0] count_d,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N:0]    onehot_q,
  output logic [CW-1:0] count_q
);
  logic full_q;

  // The slot can take a word when empty or when it drains this cycle.
  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      onehot_q <= {{N{1'b0}}, 1'b1};
      count_q  <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) begin
        onehot_q <= onehot_d;
        count_q  <= count_d;
      end
    end
  end
endmodule

// File: rtl/tally_steer.sv
module tally_steer
  import tally_pkg::*;
#(
  parameter int unsigned N        = 8,
  parameter bit          COUNT_EN = 1'b1,
  parameter bit          REG_OUT  = 1'b1,
  localparam int unsigned CW = count_width(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_bits,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N:0]    out_onehot,
  output logic [CW-1:0] out_count
);
  logic [N:0]    onehot_c;
  logic [CW-1:0] count_c;

  tally_chain #(.N(N)) chain_i (
    .bits_i   (in_bits),
    .onehot_o (onehot_c)
  );

  if (COUNT_EN) begin : g_enc
    tally_encode #(.N(N), .CW(CW)) enc_i (
      .onehot_i (onehot_c),
      .count_o  (count_c)
    );
  end else begin : g_no_enc
    assign count_c = '0;
  end

  if (REG_OUT) begin : g_reg
    tally_out_slot #(.N(N), .CW(CW)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .onehot_d  (onehot_c),
      .count_d   (count_c),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .onehot_q  (out_onehot),
      .count_q   (out_count)
    );
  end else begin : g_comb
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_onehot = onehot_c;
    assign out_count  = count_c;
  end
endmodule

// File: rtl/tally_steer_chk.sv
module tally_steer_chk #(
  parameter int unsigned N        = 8,
  parameter bit          COUNT_EN = 1'b1,
  parameter bit          REG_OUT  = 1'b1,
  parameter int unsigned CW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [N-1:0]  in_bits,
  input logic          out_valid,
  input logic          out_ready,
  input logic [N:0]    out_onehot,
  input logic [CW-1:0] out_count
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_onehot) == 1);

  if (COUNT_EN) begin : g_cnt
    // R6: the binary count points at the asserted one-hot line.
    p_count_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(out_count) <= int'(N)) && out_onehot[out_count]);
  end else begin : g_nocnt
    p_count_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_count == '0);
  end

  if (REG_OUT) begin : g_reg
    p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!out_valid && out_onehot == {{N{1'b0}}, 1'b1}));
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_onehot) && $stable(out_count)));
  end else begin : g_comb
    p_zero_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_bits == '0) |-> out_onehot[0]);
  end
endmodule

bind tally_steer tally_steer_chk #(
  .N(N), .COUNT_EN(COUNT_EN), .REG_OUT(REG_OUT), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
  .out_onehot(out_onehot), .out_count(out_count)
);

// File: tb/tally_steer_tb_top.sv
module tally_steer_tb_top;
  localparam int unsigned NB  = 8;
  localparam int unsigned CWB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;

  // Registered, encoder on, N=8
  logic            a_in_valid = 1'b0, a_out_ready = 1'b1;
  logic [NB-1:0]   a_bits = '0;
  logic            a_in_ready, a_out_valid;
  logic [NB:0]     a_onehot;
  logic [CWB-1:0]  a_count;

  // Combinational, encoder off, N=2
  logic       b_in_valid = 1'b0, b_out_ready = 1'b0;
  logic [1:0] b_bits = '0;
  logic       b_in_ready, b_out_valid;
  logic [2:0] b_onehot;
  logic [1:0] b_count;

  tally_steer #(.N(NB), .COUNT_EN(1'b1), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(a_in_valid), .in_ready(a_in_ready),
    .in_bits(a_bits), .out_valid(a_out_valid), .out_ready(a_out_ready),
    .out_onehot(a_onehot), .out_count(a_count)
  );

  tally_steer #(.N(2), .COUNT_EN(1'b0), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(b_in_valid), .in_ready(b_in_ready),
    .in_bits(b_bits), .out_valid(b_out_valid), .out_ready(b_out_ready),
    .out_onehot(b_onehot), .out_count(b_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [NB-1:0] w);
    int c = 0;
    for (int i = 0; i < int'(NB); i++) c += int'(w[i]);
    return c;
  endfunction

  // Push one word into the registered copy and check it one edge later.
  task automatic push_and_check(input logic [NB-1:0] w, input string req);
    logic [NB:0] exp_oh;
    exp_oh = (NB+1)'(1) << ones(w);
    @(negedge clk);
    a_bits = w; a_in_valid = 1'b1;
    @(negedge clk);
    check(a_out_valid == 1'b1, {req, " valid"}, a_out_valid, 1);
    check(a_onehot == exp_oh, {req, " onehot"}, a_onehot, exp_oh);
    check(int'(a_count) == ones(w), {req, " count R6"}, a_count, ones(w));
    check($countones(a_onehot) == 1, "R2 single line", $countones(a_onehot), 1);
    a_in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(a_out_valid == 1'b0, "R7 reset valid", a_out_valid, 0);
    check(a_onehot == 9'b1, "R7 reset onehot", a_onehot, 1);
    check(a_count == '0, "R7 reset count", a_count, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_edges;
    push_and_check('0, "R3 all zero");
    push_and_check('1, "R4 all ones");
    push_and_check(8'h80, "R1 top bit only");
    push_and_check(8'h01, "R1 low bit only");
  endtask

  task automatic t_exhaustive;
    for (int v = 0; v < 256; v++) push_and_check(NB'(v), "R1 exhaustive");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    a_out_ready = 1'b0;
    a_bits = 8'h07; a_in_valid = 1'b1;
    @(negedge clk);
    check(a_onehot == 9'h008, "R8 first word", a_onehot, 9'h008);
    check(a_in_ready == 1'b0, "R8 ready low", a_in_ready, 0);
    a_bits = 8'hFF;
    @(negedge clk);
    check(a_onehot == 9'h008 && a_count == 4'd3, "R8 held", a_onehot, 9'h008);
    check(a_out_valid == 1'b1, "R8 still valid", a_out_valid, 1);
    a_out_ready = 1'b1;
    @(negedge clk);
    check(a_onehot == 9'h100, "R8 next word", a_onehot, 9'h100);
    check(a_count == 4'd8, "R8 next count", a_count, 8);
    a_in_valid = 1'b0;
    @(negedge clk);
    check(a_out_valid == 1'b0, "R7 drained", a_out_valid, 0);
  endtask

  task automatic t_small;
    logic [2:0] exp_tab [4];
    exp_tab[0] = 3'b001; exp_tab[1] = 3'b010; exp_tab[2] = 3'b010; exp_tab[3] = 3'b100;
    for (int v = 0; v < 4; v++) begin
      b_bits = 2'(v);
      #1;
      check(b_onehot == exp_tab[v], "R5 two-input map", b_onehot, exp_tab[v]);
      check(b_count == 2'b00, "R6 count disabled", b_count, 0);
    end
    b_in_valid = 1'b1; b_out_ready = 1'b0;
    #1;
    check(b_out_valid == 1'b1 && b_in_ready == 1'b0, "R9 pass-through", {b_out_valid, b_in_ready}, 2'b10);
    b_in_valid = 1'b0; b_out_ready = 1'b1;
    #1;
    check(b_out_valid == 1'b0 && b_in_ready == 1'b1, "R9 pass-through", {b_out_valid, b_in_ready}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_edges();
    t_exhaustive();
    t_backpressure();
    t_small();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule